// File: doc/BRIEF.md
# Burst Bus Cycle Sequencer

This block is the bus-master side of a 32-bit processor-style external bus. A requester presents a read or write with its attributes: code or data, locked, cacheable, and whether the transaction needs two back-to-back cycles. The sequencer then runs the bus cycle. It drives an address strobe together with the cycle-definition bits and the double-word address. It samples a single-transfer ready and a burst ready from the system, and it drives a last-transfer indicator.

A cacheable data or code read can grow into a line fill. This happens when the system grants cacheability in the clock before the first ready. The fill then moves four double-words, one per clock of burst ready. The system can back the master off at any point. When that happens the sequencer floats its outputs and later restarts the interrupted cycle from its first clock.

Every accepted data beat is reported to the requester with its beat index. Completion is reported with a flag that says whether a whole line arrived. The requester holds its request until it sees completion.

Top module: `burst_bus_seq`

## Requirements
- R1: Out of reset the sequencer is idle. The strobe, cycle bits, address, lock, last-transfer, pair-hold, beat and completion outputs are 0, and bus_drive is 1.
- R2: Each bus cycle begins with addr_strobe high for exactly one clock, and a cycle restarted after backoff begins the same way. While a cycle is active, {cyc_mem,cyc_data,cyc_wr} reads 1-1-0 for a data read, 1-0-0 for a code read and 1-1-1 for any write. Write takes precedence over req_code. All three bits are 0 when no cycle is active.
- R3: Both readies are ignored in the strobe clock. A transfer completes only on a later clock in which xfer_rdy or burst_rdy is high.
- R4: Each sampled ready accepts one beat. beat_valid is high in the following clock, and beat_idx gives the beat number starting at 0.
- R5: A cacheable read becomes a four-beat line fill when cache_ok was high in the clock before its first ready and that ready is burst_rdy alone. The fill completes with done_line high.
- R6: A write, a locked read, a non-cacheable read or a two-cycle transaction is always a single transfer per cycle, whatever cache_ok does.
- R7: If xfer_rdy is high in a data clock, that beat is the last one, even when burst_rdy is also high. A fill cut short this way completes with done_line low.
- R8: last_xfer is high in every active clock of a cycle that cannot become a fill, and on the fourth beat of a fill. It is low elsewhere.
- R9: backoff overrides both readies in an active clock. The next clock has bus_drive low, and the beat count restarts. The cycle restarts with a new strobe one clock after backoff drops.
- R10: For a two-cycle transaction, multi_hold is high from the first strobe until the second cycle's address is driven. That address is the first address plus one.
- R11: done pulses for one clock, in the same clock as the final beat report. A new request is not started in that clock, nor while backoff is high.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until done |
| req_write | input | 1 | 1 = write |
| req_code | input | 1 | 1 = code fetch (reads only) |
| req_lock | input | 1 | Locked cycle |
| req_cacheable | input | 1 | Requester allows a line fill |
| req_pair | input | 1 | Transaction needs two bus cycles |
| req_addr | input | ADDR_W | Double-word address |
| xfer_rdy | input | 1 | Single-transfer ready |
| burst_rdy | input | 1 | Burst ready |
| cache_ok | input | 1 | System grants cacheability |
| backoff | input | 1 | System forces the master off the bus |
| addr_strobe | output | 1 | Start-of-cycle strobe |
| cyc_mem | output | 1 | Memory space bit |
| cyc_data | output | 1 | Data (1) or code (0) bit |
| cyc_wr | output | 1 | Write (1) or read (0) bit |
| bus_addr | output | ADDR_W | Cycle address |
| bus_lock | output | 1 | Locked cycle indicator |
| last_xfer | output | 1 | Next ready ends the cycle |
| multi_hold | output | 1 | Multi-cycle transaction in progress |
| bus_drive | output | 1 | 0 while outputs are floated |
| beat_valid | output | 1 | A data beat was accepted |
| beat_idx | output | CNT_W | Number of the accepted beat |
| done | output | 1 | Transaction complete |
| done_line | output | 1 | Completion was a whole line |

## Verification
A corrupted beat count appears at the ports within one clock. It shows as a wrong beat_idx, as last_xfer rising on the wrong beat, or as done_line on a short fill. A lost fill decision shows as done after the first beat of a burst. A wrong phase after backoff appears as a missing or doubled strobe, or as bus_drive staying low, in the clock after backoff is released. The bench predicts every output on every clock, so any of these faults is reported at the first clock it becomes visible.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_OFF  = 2'd3
    } bseq_state_e;

    typedef struct packed {
        bseq_state_e st;
        logic        wr;
        logic        code;
        logic        lock;
        logic        cach;
        logic        pair;
        logic        second;
        logic        ken_prev;
        logic        beat_v;
        logic        done;
        logic        done_line;
    } bseq_ctl_t;

endpackage

// File: rtl/bbs_beat_ctr.sv
module bbs_beat_ctr #(
    parameter int W    = 2,
    parameter int MAXV = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         at_max
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt    = cnt_q;
    assign at_max = (cnt_q == W'(MAXV));

endmodule

// File: rtl/bbs_cycdef.sv
module bbs_cycdef (
    input  logic active,
    input  logic wr,
    input  logic code,
    input  logic lock,
    input  logic cach,
    input  logic pair,
    output logic mem_o,
    output logic data_o,
    output logic wr_o,
    output logic fill_ok
);

    always_comb begin
        mem_o   = active;
        data_o  = active & (wr | ~code);
        wr_o    = active & wr;
        fill_ok = ~wr & ~lock & cach & ~pair;
    end

endmodule

// File: rtl/burst_bus_seq.sv
module burst_bus_seq
    import bbs_pkg::*;
#(
    parameter int ADDR_W     = 30,
    parameter int LINE_BEATS = 4,
    parameter int CNT_W      = $clog2(LINE_BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_code,
    input  logic              req_lock,
    input  logic              req_cacheable,
    input  logic              req_pair,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              xfer_rdy,
    input  logic              burst_rdy,
    input  logic              cache_ok,
    input  logic              backoff,
    output logic              addr_strobe,
    output logic              cyc_mem,
    output logic              cyc_data,
    output logic              cyc_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_lock,
    output logic              last_xfer,
    output logic              multi_hold,
    output logic              bus_drive,
    output logic              beat_valid,
    output logic [CNT_W-1:0]  beat_idx,
    output logic              done,
    output logic              done_line
);

    localparam int LAST_BEAT = LINE_BEATS - 1;

    bseq_ctl_t         ctl_d, ctl_q;
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [CNT_W-1:0]  idx_d, idx_q;
    logic              cnt_clr, cnt_inc, keep_on;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_max;
    logic              active;
    logic              fill_ok;

    assign active = (ctl_q.st == ST_ADDR) || (ctl_q.st == ST_DATA);

    bbs_beat_ctr #(
        .W    (CNT_W),
        .MAXV (LAST_BEAT)
    ) i_beat_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .inc    (cnt_inc),
        .cnt    (cnt),
        .at_max (cnt_max)
    );

    bbs_cycdef i_cycdef (
        .active  (active),
        .wr      (ctl_q.wr),
        .code    (ctl_q.code),
        .lock    (ctl_q.lock),
        .cach    (ctl_q.cach),
        .pair    (ctl_q.pair),
        .mem_o   (cyc_mem),
        .data_o  (cyc_data),
        .wr_o    (cyc_wr),
        .fill_ok (fill_ok)
    );

    always_comb begin
        ctl_d           = ctl_q;
        addr_d          = addr_q;
        idx_d           = '0;
        ctl_d.beat_v    = 1'b0;
        ctl_d.done      = 1'b0;
        ctl_d.done_line = 1'b0;
        cnt_clr         = 1'b0;
        cnt_inc         = 1'b0;
        keep_on         = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                // one clock of rest after completion; never start under backoff (R11)
                if (req_valid && !ctl_q.done && !backoff) begin
                    ctl_d.st     = ST_ADDR;
                    ctl_d.wr     = req_write;
                    ctl_d.code   = req_code;
                    ctl_d.lock   = req_lock;
                    ctl_d.cach   = req_cacheable;
                    ctl_d.pair   = req_pair;
                    ctl_d.second = 1'b0;
                    addr_d       = req_addr;
                    cnt_clr      = 1'b1;
                end
            end
            ST_ADDR: begin
                // readies are not looked at in the strobe clock (R3)
                ctl_d.ken_prev = cache_ok;
                if (backoff) begin
                    ctl_d.st = ST_OFF;
                    cnt_clr  = 1'b1;
                end else begin
                    ctl_d.st = ST_DATA;
                end
            end
            ST_DATA: begin
                ctl_d.ken_prev = cache_ok;
                if (backoff) begin
                    ctl_d.st = ST_OFF;
                    cnt_clr  = 1'b1;
                end else if (xfer_rdy || burst_rdy) begin
                    ctl_d.beat_v = 1'b1;
                    idx_d        = cnt;
                    keep_on      = !xfer_rdy && !cnt_max &&
                                   ((cnt != '0) || (fill_ok && ctl_q.ken_prev));
                    if (keep_on) begin
                        cnt_inc = 1'b1;
                    end else begin
                        cnt_clr = 1'b1;
                        if (ctl_q.pair && !ctl_q.second) begin
                            ctl_d.second = 1'b1;
                            addr_d       = addr_q + ADDR_W'(1);
                            ctl_d.st     = ST_ADDR;
                        end else begin
                            ctl_d.st        = ST_IDLE;
                            ctl_d.done      = 1'b1;
                            ctl_d.done_line = cnt_max;
                        end
                    end
                end
            end
            default: begin
                if (!backoff) begin
                    ctl_d.st = ST_ADDR;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            addr_q <= '0;
            idx_q  <= '0;
        end else begin
            ctl_q  <= ctl_d;
            addr_q <= addr_d;
            idx_q  <= idx_d;
        end
    end

    assign addr_strobe = (ctl_q.st == ST_ADDR);
    assign bus_addr    = active ? addr_q : '0;
    assign bus_lock    = active & ctl_q.lock;
    assign last_xfer   = active & (!fill_ok || cnt_max);
    assign multi_hold  = (ctl_q.st != ST_IDLE) & ctl_q.pair & ~ctl_q.second;
    assign bus_drive   = (ctl_q.st != ST_OFF);
    assign beat_valid  = ctl_q.beat_v;
    assign beat_idx    = idx_q;
    assign done        = ctl_q.done;
    assign done_line   = ctl_q.done_line;

endmodule

// File: rtl/bbs_checker.sv
module bbs_checker (
    input logic clk,
    input logic rst_n,
    input logic addr_strobe,
    input logic cyc_mem,
    input logic cyc_wr,
    input logic bus_lock,
    input logic backoff,
    input logic bus_drive,
    input logic last_xfer,
    input logic beat_valid,
    input logic done,
    input logic done_line
);

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |=> !addr_strobe);

    assert_strobe_has_cycdef_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |-> cyc_mem);

    assert_no_beat_from_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |=> !beat_valid);

    assert_backoff_floats_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_mem && backoff) |=> !bus_drive);

    assert_line_is_plain_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_line) |-> ($past(!cyc_wr) && $past(!bus_lock)));

    assert_line_end_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_line |-> $past(last_xfer));

    assert_done_with_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> beat_valid);

    assert_done_one_clock_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind burst_bus_seq bbs_checker i_bbs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_strobe (addr_strobe),
    .cyc_mem     (cyc_mem),
    .cyc_wr      (cyc_wr),
    .bus_lock    (bus_lock),
    .backoff     (backoff),
    .bus_drive   (bus_drive),
    .last_xfer   (last_xfer),
    .beat_valid  (beat_valid),
    .done        (done),
    .done_line   (done_line)
);

// File: tb/test_burst_bus_seq.sv
module test_burst_bus_seq;

    localparam int AW    = 30;
    localparam int BEATS = 4;
    localparam int CW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_code = 1'b0;
    logic          req_lock = 1'b0, req_cacheable = 1'b0, req_pair = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          xfer_rdy = 1'b0, burst_rdy = 1'b0, cache_ok = 1'b0, backoff = 1'b0;
    logic          addr_strobe, cyc_mem, cyc_data, cyc_wr, bus_lock, last_xfer;
    logic          multi_hold, bus_drive, beat_valid, done, done_line;
    logic [AW-1:0] bus_addr;
    logic [CW-1:0] beat_idx;

    int vectors = 0;
    int misses  = 0;
    string tag  = "R1";

    always #10 clk = ~clk;

    burst_bus_seq #(.ADDR_W(AW), .LINE_BEATS(BEATS)) i_burst_bus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_code(req_code), .req_lock(req_lock), .req_cacheable(req_cacheable),
        .req_pair(req_pair), .req_addr(req_addr), .xfer_rdy(xfer_rdy),
        .burst_rdy(burst_rdy), .cache_ok(cache_ok), .backoff(backoff),
        .addr_strobe(addr_strobe), .cyc_mem(cyc_mem), .cyc_data(cyc_data),
        .cyc_wr(cyc_wr), .bus_addr(bus_addr), .bus_lock(bus_lock),
        .last_xfer(last_xfer), .multi_hold(multi_hold), .bus_drive(bus_drive),
        .beat_valid(beat_valid), .beat_idx(beat_idx), .done(done), .done_line(done_line)
    );

    // behavioural reference: phase 0 idle, 1 strobe clock, 2 data clocks, 3 floated
    int            m_ph, m_beats, m_bi;
    bit            m_wr, m_code, m_lk, m_ca, m_pr, m_sec, m_ken, m_bv, m_dn, m_dl;
    logic [AW-1:0] m_addr;

    function automatic bit m_fillable();
        return !m_wr && !m_lk && m_ca && !m_pr;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_beats = 0; m_bi = 0; m_wr = 0; m_code = 0; m_lk = 0;
            m_ca = 0; m_pr = 0; m_sec = 0; m_ken = 0; m_bv = 0; m_dn = 0; m_dl = 0;
            m_addr = '0;
        end else begin
            bit was_done;
            bit old_ken;
            was_done = m_dn;
            old_ken  = m_ken;
            m_bv = 0; m_dn = 0; m_dl = 0; m_bi = 0;
            if (m_ph == 0) begin
                if (req_valid && !was_done && !backoff) begin
                    m_wr = req_write; m_code = req_code; m_lk = req_lock;
                    m_ca = req_cacheable; m_pr = req_pair; m_sec = 0;
                    m_addr = req_addr; m_beats = 0; m_ph = 1;
                end
            end else if (m_ph == 1) begin
                m_ken = cache_ok;
                m_ph  = backoff ? 3 : 2;
            end else if (m_ph == 2) begin
                m_ken = cache_ok;
                if (backoff) begin
                    m_ph = 3; m_beats = 0;
                end else if (xfer_rdy || burst_rdy) begin
                    m_bv = 1; m_bi = m_beats;
                    if (!xfer_rdy && m_beats < BEATS - 1 &&
                        (m_beats > 0 || (m_fillable() && old_ken))) begin
                        m_beats++;
                    end else begin
                        m_dl = (m_beats == BEATS - 1);
                        m_beats = 0;
                        if (m_pr && !m_sec) begin
                            m_sec = 1; m_addr = m_addr + 1'b1; m_ph = 1;
                        end else begin
                            m_ph = 0; m_dn = 1;
                        end
                    end
                end
                if (!m_dn) m_dl = 0;
            end else begin
                if (!backoff) m_ph = 1;
            end
        end
    end

    task automatic chk(input string sig, input string rq, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s (%s) %s: got %0h expected %0h at %0t", rq, tag, sig, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit act;
        act = (m_ph == 1) || (m_ph == 2);
        chk("addr_strobe", "R2", addr_strobe, m_ph == 1);
        chk("cyc_mem",     "R2", cyc_mem, act);
        chk("cyc_data",    "R2", cyc_data, act && (m_wr || !m_code));
        chk("cyc_wr",      "R2", cyc_wr, act && m_wr);
        chk("bus_addr",    "R10", bus_addr, act ? m_addr : '0);
        chk("bus_lock",    "R6", bus_lock, act && m_lk);
        chk("last_xfer",   "R8", last_xfer, act && (!m_fillable() || m_beats == BEATS - 1));
        chk("multi_hold",  "R10", multi_hold, (m_ph != 0) && m_pr && !m_sec);
        chk("bus_drive",   "R9", bus_drive, m_ph != 3);
        chk("beat_valid",  "R4", beat_valid, m_bv);
        chk("beat_idx",    "R4", beat_idx, m_bi);
        chk("done",        "R11", done, m_dn);
        chk("done_line",   "R5", done_line, m_dl);
    endtask

    task automatic tick(input bit nb, input bit bs, input bit ko, input bit bo);
        xfer_rdy = nb; burst_rdy = bs; cache_ok = ko; backoff = bo;
        @(posedge clk);
        @(negedge clk);
        compare();
        if (done) req_valid = 1'b0;
    endtask

    task automatic issue(input bit wr, input bit cd, input bit lk, input bit ca,
                         input bit pr, input logic [AW-1:0] a);
        req_write = wr; req_code = cd; req_lock = lk; req_cacheable = ca;
        req_pair = pr; req_addr = a; req_valid = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        compare();
        chk("reset idle strobe", "R1", addr_strobe, 0);
        chk("reset drive", "R1", bus_drive, 1);

        // R3: readies in the strobe clock must not complete a data read
        tag = "R3";
        issue(0, 0, 0, 0, 0, 30'h0000_1230);
        tick(0, 0, 0, 0);
        tick(1, 1, 0, 0);
        tick(0, 0, 0, 0);
        tick(1, 0, 0, 0);
        tick(0, 0, 0, 0);

        // R6: a single write, burst ready only
        tag = "R6";
        issue(1, 1, 0, 1, 0, 30'h0ABC_0004);
        tick(0, 0, 1, 0);
        tick(0, 0, 1, 0);
        tick(0, 1, 1, 0);
        tick(0, 0, 0, 0);

        // R5: cacheable code read grows into a four-beat line
        tag = "R5";
        issue(0, 1, 0, 1, 0, 30'h0000_0040);
        tick(0, 0, 0, 0);
        tick(0, 0, 1, 0);
        for (int i = 0; i < BEATS; i++) tick(0, 1, 0, 0);
        tick(0, 0, 0, 0);

        // R5: cacheable read without grant stays single
        tag = "R5";
        issue(0, 0, 0, 1, 0, 30'h0000_0080);
        tick(0, 0, 0, 0);
        tick(0, 0, 0, 0);
        tick(0, 1, 0, 0);
        tick(0, 0, 0, 0);

        // R6: locked cacheable read with grant stays single
        tag = "R6";
        issue(0, 0, 1, 1, 0, 30'h0000_00C0);
        tick(0, 0, 1, 0);
        tick(0, 0, 1, 0);
        tick(0, 1, 1, 0);
        tick(0, 0, 0, 0);

        // R7: single-transfer ready cuts a fill on its second beat
        tag = "R7";
        issue(0, 0, 0, 1, 0, 30'h0000_0100);
        tick(0, 0, 1, 0);
        tick(0, 0, 1, 0);
        tick(0, 1, 1, 0);
        tick(1, 1, 1, 0);
        tick(0, 0, 0, 0);

        // R7: single-transfer ready on the first beat of an eligible read
        tag = "R7";
        issue(0, 0, 0, 1, 0, 30'h0000_0140);
        tick(0, 0, 1, 0);
        tick(0, 0, 1, 0);
        tick(1, 1, 1, 0);
        tick(0, 0, 0, 0);

        // R9: backoff with ready in mid-fill, then a full restart
        tag = "R9";
        issue(0, 0, 0, 1, 0, 30'h0000_0200);
        tick(0, 0, 1, 0);
        tick(0, 0, 1, 0);
        tick(0, 1, 1, 0);
        tick(0, 1, 1, 1);
        tick(0, 0, 0, 1);
        tick(0, 0, 0, 0);
        tick(0, 0, 1, 0);
        for (int i = 0; i < BEATS; i++) tick(0, 1, 0, 0);
        tick(0, 0, 0, 0);

        // R9: backoff during the strobe clock
        tag = "R9";
        issue(1, 0, 0, 0, 0, 30'h0000_0300);
        tick(0, 0, 0, 0);
        tick(1, 0, 0, 1);
        tick(0, 0, 0, 0);
        tick(0, 0, 0, 0);
        tick(1, 0, 0, 0);
        tick(0, 0, 0, 0);

        // R10: two-cycle write, hold until second address, address plus one
        tag = "R10";
        issue(1, 0, 0, 1, 1, 30'h3FFF_FFFF);
        tick(0, 0, 1, 0);
        tick(0, 0, 1, 0);
        tick(0, 1, 1, 0);
        tick(0, 0, 1, 0);
        tick(0, 0, 0, 0);
        tick(1, 0, 0, 0);
        tick(0, 0, 0, 0);

        // R11: no start while backoff is high, one-clock rest after done
        tag = "R11";
        issue(0, 0, 0, 0, 0, 30'h0000_0400);
        tick(0, 0, 0, 1);
        tick(0, 0, 0, 1);
        tick(0, 0, 0, 0);
        tick(0, 0, 0, 0);
        tick(1, 0, 0, 0);
        req_valid = 1'b1;
        tick(0, 0, 0, 0);
        chk("rest after done", "R11", addr_strobe, 0);
        tick(0, 0, 0, 0);
        chk("restart after rest", "R11", addr_strobe, 1);
        tick(0, 0, 0, 0);
        tick(1, 0, 0, 0);
        tick(0, 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        misses++;
        $display("FAIL watchdog (%s): got hang expected completion", tag);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule